// File: doc/BRIEF.md
# Debug Trigger Arbiter and Sequencer

This block sits between the comparators of an on-chip debug unit and the CPU's breakpoint logic. On every clock it gathers all the trigger sources that are active in that cycle. These are a coprocessor software breakpoint request, a software force-trigger write, an external tag pulse and four comparator match channels. It keeps only the highest-priority source and uses it to move a small sequencer. The sequencer has an idle (disarmed) state, three intermediate states and a final state.

The block decides when a trace session runs. The session can be aligned to begin, mid or end, or tracing can be turned off. The block also raises a one-cycle forced breakpoint request. A mode bit chooses whether that request enters background debug mode or raises a software interrupt.

Software arms the sequencer and clears it through a write strobe. Software also programs a 4-bit next-state code for each pair of intermediate state and match channel.

State encoding on `seq_state`: 0 `ST_IDLE`, 1 `ST_SEQ1`, 2 `ST_SEQ2`, 3 `ST_SEQ3`, 4 `ST_FINAL`.

Named transitions:
- `SW_ARM`: IDLE to SEQ1.
- `SW_CLEAR`: any armed state to IDLE.
- `COP_STOP`: any state to IDLE, with a breakpoint.
- `FORCE_FIN`: SEQx to FINAL.
- `FORCE_STOP`: armed state to IDLE.
- `TAG_STOP`: armed state to IDLE.
- `MATCH_STEP`: SEQx to SEQy.
- `MATCH_FIN`: SEQx to FINAL, or to IDLE under end alignment or with tracing off.
- `TRACE_END`: FINAL to IDLE.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset `seq_state` is 0 (`ST_IDLE`), and `bp_req`, `bp_bdm` and `trace_active` are 0.
- R2: A write with `wr_en=1` and `wr_arm=1` while idle moves the sequencer to state 1 one cycle later. `trace_active` becomes 1 only when `cfg_align` is 2'b11 (end alignment). The other values are 2'b00 no trace, 2'b01 begin and 2'b10 mid.
- R3: In state s (1..3) a match on channel c uses code `cfg_seq[((s-1)*4+c)*4 +: 4]`. Codes 1..3 step to that state and code 4 requests the final state. Code 0 and codes above 4 make that match ignored.
- R4: When several valid matches step to intermediate states in the same cycle, the lowest-numbered channel wins.
- R5: A match whose code is 4 beats every other simultaneous match, including matches on lower-numbered channels.
- R6: With `cfg_range=1`, a match on channel 2 in the same cycle as a match on channel 0 is discarded before selection.
- R7: With begin or mid alignment, a final request enters state 4 and sets `trace_active`. In state 4, matches are ignored. `trace_done` then returns the sequencer to idle and clears `trace_active`, with a breakpoint if `cfg_bp_en=1`.
- R8: With end alignment or no trace, a final request disarms at once, clears `trace_active`, and pulses `bp_req` for exactly one cycle if `cfg_bp_en=1`.
- R9: A force write (`wr_en=1`, `wr_force=1`) while armed goes to state 4 under begin or mid alignment, with no breakpoint yet. Under end alignment or no trace it disarms, with an immediate breakpoint only if `cfg_bp_en=1`.
- R10: Priority among sources: force write, then `tag_hit`, then matches. `tag_hit` while armed disarms and breaks if `cfg_bp_en=1`.
- R11: `cop_bp_req` with `cfg_cop_en=1` outranks everything. In any state, including idle, and whatever `cfg_bp_en` is, it disarms, clears `trace_active` and pulses `bp_req` on the next cycle. With `cfg_cop_en=0` it has no effect.
- R12: `bp_bdm` equals `cfg_bdm` in a cycle where `bp_req` is 1, and is 0 otherwise.
- R13: While idle, matches, tag and force writes have no effect on state or outputs.
- R14: A hardware disarm in the same cycle as an arm write leaves the sequencer idle. A write with `wr_arm=0` while armed disarms without a breakpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_arm | input | 1 | Arm bit value carried by the write |
| wr_force | input | 1 | Force-trigger bit carried by the write |
| cfg_cop_en | input | 1 | Enables the coprocessor breakpoint request |
| cfg_bp_en | input | 1 | Enables breakpoints from sequencer events |
| cfg_bdm | input | 1 | 1: debug-mode entry, 0: software interrupt |
| cfg_align | input | 2 | Trace alignment: 00 none, 01 begin, 10 mid, 11 end |
| cfg_range | input | 1 | Range-mode match merge |
| cfg_seq | input | 48 | Next-state codes, 4 bits per state and channel |
| cop_bp_req | input | 1 | Coprocessor software breakpoint request |
| tag_hit | input | 1 | External tag pulse |
| match_in | input | 4 | Comparator match pulses, channel 0 in bit 0 |
| trace_done | input | 1 | Trace buffer has completed its session |
| bp_req | output | 1 | One-cycle forced breakpoint request |
| bp_bdm | output | 1 | Breakpoint type qualifier |
| trace_active | output | 1 | Trace session running |
| seq_state | output | 3 | Current sequencer state |

## Verification
The bench goes after cycles where several sources fire together:
- Force write together with tag and matches. A flat OR instead of a priority chain would disarm instead of entering the final state.
- A final-code match on a high channel against a step code on channel 0. A plain lowest-channel pick would step rather than finish.
- Range mode with channels 0 and 2 both hitting. A design missing the merge would leave state 3.

It also checks edge cases of the arm write and the final state:
- An arm write colliding with a hardware disarm. A wrong design would re-arm.
- A coprocessor request while idle or with breakpoints disabled. Gating it by arm state would lose the breakpoint.
- Matches and force writes in the final state or while idle. They must leave the state alone, or the trace would stop early.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int NCH_DEF    = 4;
    localparam int CODE_W_DEF = 4;
    localparam int NSEQ       = 3;
    localparam int CODE_FIN   = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEQ1  = 3'd1,
        ST_SEQ2  = 3'd2,
        ST_SEQ3  = 3'd3,
        ST_FINAL = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        AL_NONE  = 2'b00,
        AL_BEGIN = 2'b01,
        AL_MID   = 2'b10,
        AL_END   = 2'b11
    } align_e;

endpackage

// File: rtl/dbg_match_pick.sv
module dbg_match_pick
    import dbg_trig_pkg::*;
#(
    parameter int NCH    = NCH_DEF,
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic [NCH-1:0]        match_i,
    input  logic                  range_en,
    input  logic [NCH*CODE_W-1:0] codes_i,
    output logic                  hit_o,
    output logic [CODE_W-1:0]     code_o
);

    localparam logic [CODE_W-1:0] FIN = CODE_W'(CODE_FIN);

    logic [NCH-1:0]    eff;
    logic              fin_hit;
    logic              step_hit;
    logic [CODE_W-1:0] step_code;
    logic [CODE_W-1:0] cd;

    always_comb begin
        eff = match_i;
        // range mode: channel 0 absorbs a coincident channel 2 match
        if (range_en && eff[0]) begin
            eff[2] = 1'b0;
        end
        fin_hit   = 1'b0;
        step_hit  = 1'b0;
        step_code = '0;
        cd        = '0;
        // scan high to low so the lowest channel is kept last
        for (int c = NCH - 1; c >= 0; c--) begin
            cd = codes_i[c*CODE_W +: CODE_W];
            if (eff[c] && cd == FIN) begin
                fin_hit = 1'b1;
            end else if (eff[c] && cd != '0 && cd < FIN) begin
                step_hit  = 1'b1;
                step_code = cd;
            end
        end
        hit_o  = fin_hit | step_hit;
        code_o = fin_hit ? FIN : step_code;
    end

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_trig_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_arm,
    input  logic              wr_force,
    input  logic              cop_req,
    input  logic              cop_en,
    input  logic              bp_en,
    input  logic              bdm_sel,
    input  align_e            align,
    input  logic              tag_hit,
    input  logic              hit,
    input  logic [CODE_W-1:0] hit_code,
    input  logic              trace_done,
    output seq_st_e           state_q,
    output logic              bp_req_q,
    output logic              bp_bdm_q,
    output logic              trace_q
);

    seq_st_e nxt;
    logic    armed, trace_fin;
    logic    fin_req, stop_req, hw_stop, bp_set, tr_nxt;

    always_comb begin
        nxt       = state_q;
        armed     = (state_q != ST_IDLE);
        trace_fin = (align == AL_BEGIN) || (align == AL_MID);
        fin_req   = 1'b0;
        stop_req  = 1'b0;
        hw_stop   = 1'b0;
        bp_set    = 1'b0;
        if (cop_req && cop_en) begin
            // COP_STOP
            nxt     = ST_IDLE;
            bp_set  = 1'b1;
            hw_stop = 1'b1;
        end else if (armed && wr_en && wr_force) begin
            fin_req = 1'b1;                     // FORCE_FIN / FORCE_STOP
        end else if (armed && tag_hit) begin
            stop_req = 1'b1;                    // TAG_STOP
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_FINAL: if (trace_done) stop_req = 1'b1;   // TRACE_END
                ST_SEQ1, ST_SEQ2, ST_SEQ3: begin
                    if (hit) begin
                        case (hit_code)
                            CODE_W'(1): nxt = ST_SEQ1;       // MATCH_STEP
                            CODE_W'(2): nxt = ST_SEQ2;
                            CODE_W'(3): nxt = ST_SEQ3;
                            default:    fin_req = 1'b1;      // MATCH_FIN
                        endcase
                    end
                end
            endcase
        end
        if (fin_req) begin
            if (trace_fin) nxt = ST_FINAL;
            else           stop_req = 1'b1;
        end
        if (stop_req) begin
            nxt     = ST_IDLE;
            bp_set  = bp_en;
            hw_stop = 1'b1;
        end
        // software write acts only when no hardware disarm happened
        if (wr_en && !hw_stop) begin
            if (wr_arm && !armed)      nxt = ST_SEQ1;   // SW_ARM
            else if (!wr_arm && armed) nxt = ST_IDLE;   // SW_CLEAR
        end
        if (nxt == ST_IDLE)                          tr_nxt = 1'b0;
        else if (nxt == ST_FINAL && trace_fin)       tr_nxt = 1'b1;
        else if (!armed)                             tr_nxt = (align == AL_END);
        else                                         tr_nxt = trace_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_req_q <= 1'b0;
            bp_bdm_q <= 1'b0;
            trace_q  <= 1'b0;
        end else begin
            bp_req_q <= bp_set;
            bp_bdm_q <= bp_set & bdm_sel;
            trace_q  <= tr_nxt;
        end
    end

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_trig_pkg::*;
#(
    parameter int NCH    = NCH_DEF,
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_arm,
    input  logic                       wr_force,
    input  logic                       cfg_cop_en,
    input  logic                       cfg_bp_en,
    input  logic                       cfg_bdm,
    input  logic [1:0]                 cfg_align,
    input  logic                       cfg_range,
    input  logic [NSEQ*NCH*CODE_W-1:0] cfg_seq,
    input  logic                       cop_bp_req,
    input  logic                       tag_hit,
    input  logic [NCH-1:0]             match_in,
    input  logic                       trace_done,
    output logic                       bp_req,
    output logic                       bp_bdm,
    output logic                       trace_active,
    output logic [2:0]                 seq_state
);

    localparam int ROW_W = NCH * CODE_W;

    seq_st_e           st;
    logic [ROW_W-1:0]  rows [NSEQ];
    logic [ROW_W-1:0]  row;
    logic              hit;
    logic [CODE_W-1:0] hit_code;

    for (genvar s = 0; s < NSEQ; s++) begin : g_row
        assign rows[s] = cfg_seq[s*ROW_W +: ROW_W];
    end

    always_comb begin
        unique case (st)
            ST_SEQ1: row = rows[0];
            ST_SEQ2: row = rows[1];
            ST_SEQ3: row = rows[2];
            default: row = '0;
        endcase
    end

    dbg_match_pick #(.NCH(NCH), .CODE_W(CODE_W)) pick_i (
        .match_i  (match_in),
        .range_en (cfg_range),
        .codes_i  (row),
        .hit_o    (hit),
        .code_o   (hit_code)
    );

    dbg_seq_fsm #(.CODE_W(CODE_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_arm     (wr_arm),
        .wr_force   (wr_force),
        .cop_req    (cop_bp_req),
        .cop_en     (cfg_cop_en),
        .bp_en      (cfg_bp_en),
        .bdm_sel    (cfg_bdm),
        .align      (align_e'(cfg_align)),
        .tag_hit    (tag_hit),
        .hit        (hit),
        .hit_code   (hit_code),
        .trace_done (trace_done),
        .state_q    (st),
        .bp_req_q   (bp_req),
        .bp_bdm_q   (bp_bdm),
        .trace_q    (trace_active)
    );

    assign seq_state = st;

endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           wr_arm,
    input logic           wr_force,
    input logic           cfg_cop_en,
    input logic [1:0]     cfg_align,
    input logic           cop_bp_req,
    input logic [NCH-1:0] match_in,
    input logic           bp_req,
    input logic           bp_bdm,
    input logic           trace_active,
    input logic [2:0]     seq_state
);

    assert_cop_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_bp_req && cfg_cop_en) |=> (bp_req && seq_state == 3'd0 && !trace_active));

    assert_bp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |-> (seq_state == 3'd0));

    assert_bdm_qual_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_req |-> !bp_bdm);

    assert_trace_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd0) |-> !trace_active);

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd0 && !(cop_bp_req && cfg_cop_en) && !(wr_en && wr_arm))
        |=> (seq_state == 3'd0 && !bp_req));

    assert_hw_wins_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != 3'd0 && wr_en && wr_arm && wr_force && cfg_align == 2'b11)
        |=> (seq_state == 3'd0));

endmodule

bind dbg_trig_seq dbg_trig_seq_chk #(.NCH(NCH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_arm       (wr_arm),
    .wr_force     (wr_force),
    .cfg_cop_en   (cfg_cop_en),
    .cfg_align    (cfg_align),
    .cop_bp_req   (cop_bp_req),
    .match_in     (match_in),
    .bp_req       (bp_req),
    .bp_bdm       (bp_bdm),
    .trace_active (trace_active),
    .seq_state    (seq_state)
);

// File: tb/dbg_trig_seq_tb_top.sv
module dbg_trig_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_arm = 0, wr_force = 0;
    logic        cfg_cop_en = 1, cfg_bp_en = 1, cfg_bdm = 1;
    logic [1:0]  cfg_align = 2'b11;
    logic        cfg_range = 0;
    logic [47:0] cfg_seq = '0;
    logic        cop_bp_req = 0, tag_hit = 0, trace_done = 0;
    logic [3:0]  match_in = '0;
    logic        bp_req, bp_bdm, trace_active;
    logic [2:0]  seq_state;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    dbg_trig_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_arm(wr_arm), .wr_force(wr_force),
        .cfg_cop_en(cfg_cop_en), .cfg_bp_en(cfg_bp_en), .cfg_bdm(cfg_bdm),
        .cfg_align(cfg_align), .cfg_range(cfg_range), .cfg_seq(cfg_seq),
        .cop_bp_req(cop_bp_req), .tag_hit(tag_hit), .match_in(match_in),
        .trace_done(trace_done), .bp_req(bp_req), .bp_bdm(bp_bdm),
        .trace_active(trace_active), .seq_state(seq_state)
    );

    // ---------------- behavioural reference model ----------------
    int m_st;
    bit m_bp, m_bdm, m_tr;

    function automatic int code_of(int s, int c);
        return int'(cfg_seq[((s - 1) * 4 + c) * 4 +: 4]);
    endfunction

    function automatic int pick_target(int s);
        bit [3:0] m;
        if (s < 1 || s > 3) return 0;
        m = match_in;
        if (cfg_range && m[0]) m[2] = 1'b0;
        for (int c = 0; c < 4; c++)
            if (m[c] && code_of(s, c) == 4) return 4;
        for (int c = 0; c < 4; c++)
            if (m[c] && code_of(s, c) >= 1 && code_of(s, c) <= 3) return code_of(s, c);
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_bp = 0; m_bdm = 0; m_tr = 0;
        end else begin
            int  ns, tgt;
            bit  bp, stop, fin, midb;
            ns = m_st; bp = 0; stop = 0; fin = 0;
            midb = (cfg_align == 2'b01) || (cfg_align == 2'b10);
            tgt = pick_target(m_st);
            if (cop_bp_req && cfg_cop_en) begin
                ns = 0; bp = 1; stop = 1;
            end else if (m_st != 0 && wr_en && wr_force) fin = 1;
            else if (m_st != 0 && tag_hit) begin ns = 0; stop = 1; bp = cfg_bp_en; end
            else if (m_st == 4) begin
                if (trace_done) begin ns = 0; stop = 1; bp = cfg_bp_en; end
            end else if (m_st != 0 && tgt == 4) fin = 1;
            else if (m_st != 0 && tgt != 0) ns = tgt;
            if (fin) begin
                if (midb) ns = 4;
                else begin ns = 0; stop = 1; bp = cfg_bp_en; end
            end
            if (wr_en && !stop) begin
                if (wr_arm && m_st == 0) ns = 1;
                else if (!wr_arm && m_st != 0) ns = 0;
            end
            if (ns == 0) m_tr = 0;
            else if (ns == 4 && midb) m_tr = 1;
            else if (m_st == 0) m_tr = (cfg_align == 2'b11);
            m_bp = bp; m_bdm = bp && cfg_bdm; m_st = ns;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("model state", int'(seq_state), m_st);
            chk("model bp_req", int'(bp_req), int'(m_bp));
            chk("model bp_bdm", int'(bp_bdm), int'(m_bdm));
            chk("model trace", int'(trace_active), int'(m_tr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_now(int st, int bp, int tr);
        chk("state", int'(seq_state), st);
        chk("bp_req", int'(bp_req), bp);
        chk("trace", int'(trace_active), tr);
    endtask

    task automatic set_code(int s, int c, int v);
        cfg_seq[((s - 1) * 4 + c) * 4 +: 4] = 4'(v);
    endtask

    task automatic do_arm();
        wr_en = 1; wr_arm = 1; tick(); wr_en = 0;
    endtask

    task automatic do_match(logic [3:0] m);
        match_in = m; tick(); match_in = '0;
    endtask

    task automatic do_force();
        wr_en = 1; wr_arm = 1; wr_force = 1; tick(); wr_en = 0; wr_force = 0;
    endtask

    task automatic do_tag();
        tag_hit = 1; tick(); tag_hit = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        set_code(1, 0, 2); set_code(1, 1, 3); set_code(1, 2, 0); set_code(1, 3, 4);
        set_code(2, 0, 1); set_code(2, 1, 0); set_code(2, 2, 3); set_code(2, 3, 9);
        set_code(3, 0, 0); set_code(3, 1, 4); set_code(3, 2, 4); set_code(3, 3, 1);
        repeat (3) tick();
        cur_req = "R1";
        expect_now(0, 0, 0);
        chk("bp_bdm", int'(bp_bdm), 0);
        rst_n = 1;
        tick();

        // R13: idle ignores triggers
        cur_req = "R13";
        match_in = 4'hF; tag_hit = 1; wr_en = 1; wr_arm = 0; wr_force = 1;
        tick();
        match_in = '0; tag_hit = 0; wr_en = 0; wr_force = 0;
        expect_now(0, 0, 0);

        // R2: arm with end alignment
        cur_req = "R2";
        do_arm(); expect_now(1, 0, 1);
        // R4: lowest channel wins among steps
        cur_req = "R4";
        do_match(4'b0011); expect_now(2, 0, 1);
        // R3: code 0 and code 9 ignored, code 3 steps
        cur_req = "R3";
        do_match(4'b1010); expect_now(2, 0, 1);
        do_match(4'b0100); expect_now(3, 0, 1);
        do_match(4'b1000); expect_now(1, 0, 1);
        // R5 + R8: final code on ch3 beats ch0, end alignment disarms with a pulse
        cur_req = "R5";
        do_match(4'b1001); expect_now(0, 1, 0);
        cur_req = "R12";
        chk("bp_bdm", int'(bp_bdm), 1);
        tick();
        cur_req = "R8";
        expect_now(0, 0, 0);

        // R6: range merge
        cur_req = "R6";
        do_arm(); do_match(4'b0010); expect_now(3, 0, 1);
        cfg_range = 1; do_match(4'b0101); expect_now(3, 0, 1);
        cfg_range = 0; cfg_bdm = 0;
        do_match(4'b0101); expect_now(0, 1, 0);
        cur_req = "R12";
        chk("bp_bdm", int'(bp_bdm), 0);
        cfg_bdm = 1;

        // R10: tag beats match
        cur_req = "R10";
        do_arm(); tag_hit = 1; match_in = 4'b0001; tick(); tag_hit = 0; match_in = '0;
        expect_now(0, 1, 0);

        // R9 + R10: force beats tag under begin alignment
        cur_req = "R9";
        cfg_align = 2'b01;
        do_arm(); expect_now(1, 0, 0);
        tag_hit = 1; match_in = 4'b0001; do_force(); tag_hit = 0; match_in = '0;
        expect_now(4, 0, 1);
        cur_req = "R10";
        do_tag(); expect_now(0, 1, 0);

        // R7: mid alignment final state and trace completion
        cur_req = "R7";
        cfg_align = 2'b10;
        do_arm(); do_match(4'b1000); expect_now(4, 0, 1);
        do_match(4'b0111); expect_now(4, 0, 1);
        tick(); expect_now(4, 0, 1);
        trace_done = 1; tick(); trace_done = 0;
        expect_now(0, 1, 0);

        // R9: end alignment with breakpoints off, and no-trace mode
        cur_req = "R9";
        cfg_align = 2'b11; cfg_bp_en = 0;
        do_arm(); do_force(); expect_now(0, 0, 0);
        cfg_align = 2'b00; cfg_bp_en = 1;
        do_arm(); expect_now(1, 0, 0);
        do_force(); expect_now(0, 1, 0);

        // R11: coprocessor request
        cur_req = "R11";
        cfg_align = 2'b11; cfg_bp_en = 0;
        cop_bp_req = 1; tick(); cop_bp_req = 0;
        expect_now(0, 1, 0);
        do_arm();
        cop_bp_req = 1; do_force(); cop_bp_req = 0;
        expect_now(0, 1, 0);
        cfg_cop_en = 0;
        do_arm(); cop_bp_req = 1; tick(); cop_bp_req = 0;
        expect_now(1, 0, 1);
        cfg_cop_en = 1; cfg_bp_en = 1;

        // R14: hardware disarm beats arm write; software clear
        cur_req = "R14";
        do_force(); expect_now(0, 1, 0);
        cop_bp_req = 1; wr_en = 1; wr_arm = 1; tick(); cop_bp_req = 0; wr_en = 0;
        expect_now(0, 1, 0);
        do_arm(); expect_now(1, 0, 1);
        wr_en = 1; wr_arm = 0; tick(); wr_en = 0;
        expect_now(0, 0, 0);
        tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule